// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and the write engine of a NOR-style flash array. Each bus write carries a command code in its low byte. The block follows multi-write sequences: a program setup, then the target write; an erase setup, then a confirm. It launches the engine for each sequence and latches the target address and data. It also handles erase suspend and resume with the engine, and flags an error when an erase sequence is broken.

The engine is modelled here as a cycle counter. A program finishes after `PROG_CYCLES` counted cycles and an erase after `ERASE_CYCLES` counted cycles. The erase count pauses while a suspend is requested. The block also drives a read-mode select, so that a read returns either array data or the status byte. Whenever an operation is in flight, the select is forced to status.

The reset/powerdown input is active low and asynchronous. It abandons any operation at once.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_status` is 0, `status` is 8'h80, and `susp_req` and `eng_start` are 0. The status layout is: bit7 ready (1 = no operation running), bit6 erase suspended, bit5 erase error, bit4 program error, bits 3..0 zero.
- R2: When idle, command 8'hFF selects array reads (`rd_status`=0) and 8'h70 selects status reads (`rd_status`=1).
- R3: Command 8'h40 or 8'h10 arms a program. The next write latches `wr_addr` and `wr_data` into `lat_addr` and `lat_data`. One cycle later it pulses `eng_start` for exactly one cycle, with `eng_is_erase`=0. Ready drops.
- R4: A program ends with ready returning to 1 exactly PROG_CYCLES+2 cycles after the target write edge.
- R5: 8'h20 followed directly by 8'hD0 latches the confirm write's address, pulses `eng_start` with `eng_is_erase`=1, and keeps `lat_addr` unchanged until the erase ends. With no suspend, ready returns ERASE_CYCLES+2 cycles after the confirm edge.
- R6: 8'h20 followed by any code other than 8'hD0 sets status bits 5 and 4, forces `rd_status`=1, starts nothing, and returns to idle.
- R7: When idle, 8'h50 clears status bits 5 and 4.
- R8: While an operation runs, `rd_status` stays 1. During a program, 8'hB0 and every other code have no effect.
- R9: During an erase, 8'hB0 raises `susp_req` in the next cycle. Codes other than 8'h70 and 8'hB0 are ignored.
- R10: Two cycles after the suspend write, status bit6 and ready read 1. Erase completion is delayed by exactly the cycles between the suspend write and the resume write.
- R11: While suspended, 8'hFF and 8'h70 switch the read mode. All other codes except 8'hD0 (for example 8'h40 and 8'h20) are ignored.
- R12: 8'hD0 as resume clears `susp_req` and bit6, drops ready and restores status reads. In idle, 8'hD0 has no effect.
- R13: Driving `rst_n` low during any operation returns all outputs to their R1 values at once, and the next operation times normally.
- R14: In idle, codes outside the set above leave `rd_status` and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset / powerdown |
| wr_en | input | 1 | Bus write strobe, one write per asserted cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command code in bits 7..0 |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_is_erase | output | 1 | Operation kind for the launch: 1 erase, 0 program |
| susp_req | output | 1 | Erase suspend request to the engine |
| rd_status | output | 1 | Read-path select: 1 status byte, 0 array |
| lat_addr | output | AW | Latched target address |
| lat_data | output | DW | Latched target data |
| status | output | 8 | Status byte |

## Verification
A sequencer stuck in the wrong state shows at once at the ports. A command that should be ignored changes `rd_status` or `status` on the very next sample. A missed suspend leaves bit6 low two cycles after the suspend write. Counting errors in the engine, or pausing at the wrong time, move the ready edge. The bench therefore checks ready both the cycle before the expected completion and at it, including after a suspend window of known length. A randomized run of idle commands is compared write by write against a reference model of the read mode and error bits.

// File: rtl/fci_pkg.sv
package fci_pkg;
    localparam logic [7:0] OP_PROG_A      = 8'h40;
    localparam logic [7:0] OP_PROG_B      = 8'h10;
    localparam logic [7:0] OP_ERASE       = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR       = 8'h50;

    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;
    localparam int SB_EERR  = 5;
    localparam int SB_PERR  = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PROG, ST_ERASE, ST_SPEND, ST_SUSP
    } seq_state_e;
endpackage

// File: rtl/fci_engine.sv
module fci_engine #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic is_erase_i,
    input  logic pause_i,
    output logic done_o,
    output logic suspended_o
);
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          running;
        logic          done;
        logic          susp;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t e_q, e_d;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        e_d.susp = e_q.running & pause_i;
        if (start_i) begin
            e_d.running = 1'b1;
            e_d.cnt     = is_erase_i ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
        end else if (e_q.running && !pause_i) begin
            if (e_q.cnt == '0) begin
                e_d.running = 1'b0;
                e_d.done    = 1'b1;
            end else begin
                e_d.cnt = e_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign done_o      = e_q.done;
    assign suspended_o = e_q.susp;

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_paused_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.running && pause_i && !start_i) |=> (!done_o && $stable(e_q.cnt)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int AW           = 18,
    parameter int DW           = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          eng_start,
    output logic          eng_is_erase,
    output logic          susp_req,
    output logic          rd_status,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data,
    output logic [7:0]    status
);
    typedef struct packed {
        seq_state_e    st;
        logic          rd_status;
        logic          perr;
        logic          eerr;
        logic          susp_req;
        logic          start;
        logic          is_erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } regs_t;

    regs_t r_q, r_d;
    logic  eng_done, eng_susp;
    logic  busy;
    logic [7:0] cmd;

    assign cmd  = wr_data[7:0];
    assign busy = (r_q.st == ST_PROG) || (r_q.st == ST_ERASE) || (r_q.st == ST_SPEND);

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        case (r_q.st)
            ST_IDLE: if (wr_en) begin
                case (cmd)
                    OP_READ_ARRAY:        r_d.rd_status = 1'b0;
                    OP_READ_STATUS:       r_d.rd_status = 1'b1;
                    OP_CLEAR: begin
                        r_d.perr = 1'b0;
                        r_d.eerr = 1'b0;
                    end
                    OP_PROG_A, OP_PROG_B: r_d.st = ST_PSETUP;
                    OP_ERASE:             r_d.st = ST_ESETUP;
                    default: ;
                endcase
            end
            ST_PSETUP: if (wr_en) begin
                r_d.addr      = wr_addr;
                r_d.data      = wr_data;
                r_d.start     = 1'b1;
                r_d.is_erase  = 1'b0;
                r_d.rd_status = 1'b1;
                r_d.st        = ST_PROG;
            end
            ST_ESETUP: if (wr_en) begin
                r_d.rd_status = 1'b1;
                if (cmd == OP_CONFIRM) begin
                    r_d.addr     = wr_addr;
                    r_d.data     = wr_data;
                    r_d.start    = 1'b1;
                    r_d.is_erase = 1'b1;
                    r_d.st       = ST_ERASE;
                end else begin
                    r_d.perr = 1'b1;
                    r_d.eerr = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_PROG: if (eng_done) r_d.st = ST_IDLE;
            ST_ERASE: begin
                if (eng_done) begin
                    r_d.st = ST_IDLE;
                end else if (wr_en && cmd == OP_SUSPEND) begin
                    r_d.susp_req = 1'b1;
                    r_d.st       = ST_SPEND;
                end
            end
            ST_SPEND: begin
                if (eng_done) begin
                    r_d.susp_req = 1'b0;
                    r_d.st       = ST_IDLE;
                end else if (wr_en && cmd == OP_CONFIRM) begin
                    r_d.susp_req = 1'b0;
                    r_d.st       = ST_ERASE;
                end else if (eng_susp) begin
                    r_d.st = ST_SUSP;
                end
            end
            ST_SUSP: if (wr_en) begin
                case (cmd)
                    OP_READ_ARRAY:  r_d.rd_status = 1'b0;
                    OP_READ_STATUS: r_d.rd_status = 1'b1;
                    OP_CONFIRM: begin
                        r_d.susp_req  = 1'b0;
                        r_d.rd_status = 1'b1;
                        r_d.st        = ST_ERASE;
                    end
                    default: ;
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    fci_engine #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (r_q.start),
        .is_erase_i (r_q.is_erase),
        .pause_i    (r_q.susp_req),
        .done_o     (eng_done),
        .suspended_o(eng_susp)
    );

    always_comb begin
        status           = 8'h00;
        status[SB_READY] = !busy;
        status[SB_SUSP]  = (r_q.st == ST_SUSP);
        status[SB_EERR]  = r_q.eerr;
        status[SB_PERR]  = r_q.perr;
    end

    assign eng_start    = r_q.start;
    assign eng_is_erase = r_q.is_erase;
    assign susp_req     = r_q.susp_req;
    assign rd_status    = r_q.rd_status;
    assign lat_addr     = r_q.addr;
    assign lat_data     = r_q.data;

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_busy_reads_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status[SB_READY] |-> rd_status);
    assert_latch_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[SB_READY] && !eng_start) |-> $stable(lat_addr));
    assert_suspend_erase_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> eng_is_erase);
    assert_suspend_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_SUSP] |-> (susp_req && status[SB_READY]));
    assert_done_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> !status[SB_READY]);
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int PC = 8;
    localparam int EC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_start, eng_is_erase, susp_req, rd_status;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_data;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] last_data;
    logic m_rd, m_perr, m_eerr;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_ctrl #(.AW(AW), .DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_start(eng_start), .eng_is_erase(eng_is_erase), .susp_req(susp_req),
        .rd_status(rd_status), .lat_addr(lat_addr), .lat_data(lat_data), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = DW'($urandom);
        wr_data[7:0] = c;
        last_data = wr_data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic logic [7:0] idle_status();
        return {1'b1, 1'b0, m_eerr, m_perr, 4'h0};
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k, j, r, t;
        logic [AW-1:0] ea;
        void'($urandom(32'd4242));

        // R1 reset values
        repeat (3) @(negedge clk);
        chk("R1 rd_status", rd_status, 0);
        chk("R1 status", status, 8'h80);
        chk("R1 susp_req", susp_req, 0);
        chk("R1 eng_start", eng_start, 0);
        rst_n = 1'b1;

        // R2 read mode select
        wr(0, 8'h70);
        chk("R2 status mode", rd_status, 1);
        wr(0, 8'hFF);
        chk("R2 array mode", rd_status, 0);

        // R3/R4/R8 program
        wr(0, 8'h10);
        wr(18'h0123, 8'h5A);
        k = cyc;
        chk("R3 start", eng_start, 1);
        chk("R3 kind", eng_is_erase, 0);
        chk("R3 addr", lat_addr, 18'h0123);
        chk("R3 data", lat_data, last_data);
        chk("R3 busy", status[7], 0);
        @(negedge clk);
        chk("R3 single pulse", eng_start, 0);
        wr(0, 8'hB0);
        chk("R8 no suspend in program", susp_req, 0);
        wr(0, 8'hFF);
        chk("R8 status kept", rd_status, 1);
        wait_cyc(k + PC + 1);
        chk("R4 still busy", status[7], 0);
        wait_cyc(k + PC + 2);
        chk("R4 ready", status[7], 1);

        // R5 erase without suspend
        wr(0, 8'h20);
        wr(18'h2AAAA, 8'hD0);
        k = cyc;
        chk("R5 start", eng_start, 1);
        chk("R5 kind", eng_is_erase, 1);
        chk("R5 addr", lat_addr, 18'h2AAAA);
        wait_cyc(k + EC + 1);
        chk("R5 still busy", status[7], 0);
        wait_cyc(k + EC + 2);
        chk("R5 ready", status[7], 1);

        // R9/R10/R11/R12 erase with suspend
        ea = 18'h01F00;
        wr(0, 8'h20);
        wr(ea, 8'hD0);
        k = cyc;
        wr(18'h3FFFF, 8'h40);
        chk("R9 other code ignored", susp_req, 0);
        wr(18'h15555, 8'hB0);
        j = cyc;
        chk("R9 suspend request", susp_req, 1);
        chk("R10 not yet suspended", status, 8'h00);
        wait_cyc(j + 2);
        chk("R10 suspended flag", status, 8'hC0);
        wr(0, 8'hFF);
        chk("R11 array in suspend", rd_status, 0);
        wr(0, 8'h40);
        chk("R11 program ignored", status, 8'hC0);
        wr(0, 8'h20);
        chk("R11 erase ignored", status, 8'hC0);
        chk("R11 mode kept", rd_status, 0);
        wr(0, 8'h70);
        chk("R11 status in suspend", rd_status, 1);
        wr(0, 8'hFF);
        wr(0, 8'hD0);
        r = cyc;
        chk("R12 resume clears request", susp_req, 0);
        chk("R12 resume status", status, 8'h00);
        chk("R12 resume read mode", rd_status, 1);
        chk("R5 latch held", lat_addr, ea);
        t = k + EC + 2 + (r - j);
        wait_cyc(t - 1);
        chk("R10 delayed busy", status[7], 0);
        wait_cyc(t);
        chk("R10 delayed ready", status[7], 1);

        // R6/R7 broken erase and clear
        wr(0, 8'h20);
        wr(0, 8'h55);
        chk("R6 error bits", status, 8'hB0);
        chk("R6 status mode", rd_status, 1);
        chk("R6 no start", eng_start, 0);
        wr(0, 8'h50);
        chk("R7 cleared", status, 8'h80);

        // R12 D0 in idle
        wr(0, 8'hFF);
        wr(0, 8'hD0);
        chk("R12 idle D0 mode", rd_status, 0);
        chk("R12 idle D0 status", status, 8'h80);
        chk("R12 idle D0 start", eng_start, 0);

        // R14/R2/R6/R7 randomized idle commands
        m_rd = 1'b0; m_perr = 1'b0; m_eerr = 1'b0;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            case ($urandom % 5)
                0: c = 8'hFF;
                1: c = 8'h70;
                2: c = 8'h50;
                3: c = 8'h20;
                default: ;
            endcase
            if (c == 8'h40 || c == 8'h10) c = 8'h3C;
            wr(AW'($urandom), c);
            if (c == 8'h20) begin
                logic [7:0] n;
                n = 8'($urandom);
                if (n == 8'hD0) n = 8'hD1;
                wr(0, n);
                m_perr = 1'b1; m_eerr = 1'b1; m_rd = 1'b1;
            end else if (c == 8'hFF) m_rd = 1'b0;
            else if (c == 8'h70) m_rd = 1'b1;
            else if (c == 8'h50) begin m_perr = 1'b0; m_eerr = 1'b0; end
            chk("R14 random mode", rd_status, m_rd);
            chk("R14 random status", status, idle_status());
        end

        // R13 abort mid erase
        wr(0, 8'h20);
        wr(18'h00ABC, 8'hD0);
        wr(0, 8'hB0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R13 status", status, 8'h80);
        chk("R13 susp_req", susp_req, 0);
        chk("R13 rd_status", rd_status, 0);
        chk("R13 lat_addr", lat_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wr(0, 8'h40);
        wr(18'h00777, 8'h11);
        k = cyc;
        wait_cyc(k + PC + 1);
        chk("R13 clean restart busy", status[7], 0);
        wait_cyc(k + PC + 2);
        chk("R13 clean restart ready", status[7], 1);

        finish_run();
    end
endmodule